// File: doc/BRIEF.md
# Claim/Complete Platform Interrupt Controller

This block collects level-sensitive interrupt requests from a set of sources and hands them out to several target contexts, such as processor harts or privilege levels. Every source carries a priority, and every context has a private set of enable bits and a private priority threshold. For each context the block picks the best source. A source qualifies when it is pending, enabled for that context, and its priority is strictly above that context's threshold. While such a source exists, the context's interrupt line is asserted.

Software takes an interrupt by reading the context's claim/complete register. The read returns the winning source ID (0 when none qualifies) and at the same moment moves that source from pending to in-service. While a source is in service it cannot request again. Writing the same ID back to the claim/complete register ends the service, and the source's gateway can then latch a new request. All registers are reached over a simple single-cycle memory-mapped bus whose read data returns one cycle after the request.

Top module: `irq_claim_ctrl`

## Requirements
- R1: After synchronous reset every interrupt line is low and every priority, enable and threshold register reads 0; a claim read returns 0.
- R2: The priority of source s (1..N) sits at byte address 4*s and keeps only the low PRIO_W bits of a write; address 0 (reserved ID 0) ignores writes and reads 0.
- R3: The enable word of context c sits at 0x200 + 0x10*c; source s is bit s%32 of word s/32 (word k at +4*k). Bit 0 always reads 0.
- R4: The threshold of context c sits at 0x400 + 0x10*c and its claim/complete register at 0x404 + 0x10*c. A source qualifies only when its priority is strictly greater than the threshold, so equal priority does not interrupt.
- R5: Among the qualifying sources of a context, the highest priority wins; on equal priority the lowest source ID wins.
- R6: A context's interrupt line is registered: a source that turns pending at one clock edge raises the line at the following edge, not the same one.
- R7: A claim read returns the winning ID on the next cycle and clears that source's pending bit; a claim read with no winner returns 0 and changes nothing.
- R8: A claimed source stays out of arbitration, even with its input held high, until its ID is written to a claim/complete register; after that a held-high input makes it pending again.
- R9: A gateway latches a request: a source input that is high for one cycle and then drops stays pending until claimed.
- R10: A completion with ID 0, an ID above N, or addressed to a context that does not exist has no effect on an in-service source.
- R11: A source with priority 0 never interrupts any context.
- R12: Contexts are independent in enables and thresholds, but share the source: once one context claims it, it no longer asserts the other context's line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | NUM_SRC (31) | Level-high request of sources 1..N, bit s for source s |
| bus_req | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request, 0 otherwise |
| irq_o | output | NUM_CTX (2) | Registered interrupt line per context |

## Verification
The bench goes after tie-breaking on equal priority, where a design that scans from the wrong end would hand out the higher ID. It also checks a priority exactly equal to the threshold, which a non-strict compare would let through. Completion with an out-of-range ID whose low bits alias a real in-service source is tested, since a truncating compare would release the wrong source early. The bench holds an input high across a claim, which a gateway without an in-service state would re-latch at once. Finally it checks that a source enabled in two contexts drops from both lines after a single claim.

// File: rtl/icc_pkg.sv
package icc_pkg;
  localparam int BUS_AW   = 12;
  localparam int BUS_DW   = 32;
  // address split: [11:9] window, [8:4] context slot, [3:2] word in slot
  localparam int WIN_LSB  = 9;
  localparam int SLOT_LSB = 4;

  typedef enum logic [BUS_AW-WIN_LSB-1:0] {
    RG_PRIO = 3'd0,
    RG_ENA  = 3'd1,
    RG_CTX  = 3'd2
  } region_e;

  typedef struct packed {
    logic                       hit;
    region_e                    region;
    logic [WIN_LSB-SLOT_LSB-1:0] slot;
    logic [SLOT_LSB-3:0]        sub;
    logic [WIN_LSB-3:0]         idx;
  } dec_t;

  function automatic dec_t decode(input logic [BUS_AW-1:0] a);
    dec_t d;
    d.hit    = (a[1:0] == 2'b00);
    d.region = region_e'(a[BUS_AW-1:WIN_LSB]);
    d.slot   = a[WIN_LSB-1:SLOT_LSB];
    d.sub    = a[SLOT_LSB-1:2];
    d.idx    = a[WIN_LSB-1:2];
    return d;
  endfunction
endpackage

// File: rtl/icc_gateway.sv
module icc_gateway (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic take,
  input  logic done,
  output logic pend,
  output logic busy
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      busy <= 1'b0;
    end else if (take) begin
      pend <= 1'b0;
      busy <= 1'b1;
    end else begin
      if (done) busy <= 1'b0;
      if (lvl && !busy && !pend) pend <= 1'b1;
    end
  end
endmodule

// File: rtl/icc_arbiter.sv
module icc_arbiter #(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 3,
  parameter int IDW     = 5
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_SRC:1]               pend,
  input  logic [NUM_SRC:1]               en,
  input  logic [NUM_SRC:1][PRIO_W-1:0]   prio,
  input  logic [PRIO_W-1:0]              thr,
  output logic [IDW-1:0]                 win_id,
  output logic                           irq
);
  logic [PRIO_W-1:0] best_p;

  // linear scan: a later source replaces the current best only on a
  // strictly higher priority, so ties keep the lowest ID
  always_comb begin
    win_id = '0;
    best_p = '0;
    for (int s = 1; s <= NUM_SRC; s++) begin
      if (pend[s] && en[s] && (prio[s] > thr) && (prio[s] > best_p)) begin
        win_id = IDW'(s);
        best_p = prio[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (win_id != '0);
  end
endmodule

// File: rtl/icc_regs.sv
module icc_regs
  import icc_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int IDW     = 5
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              bus_req,
  input  logic                              bus_we,
  input  logic [BUS_AW-1:0]                 bus_addr,
  input  logic [BUS_DW-1:0]                 bus_wdata,
  input  logic [NUM_CTX-1:0][IDW-1:0]       win_id,
  output logic [NUM_SRC:1][PRIO_W-1:0]      prio,
  output logic [NUM_CTX-1:0][NUM_SRC:1]     en,
  output logic [NUM_CTX-1:0][PRIO_W-1:0]    thr,
  output logic [BUS_DW-1:0]                 bus_rdata,
  output logic                              claim_vld,
  output logic [IDW-1:0]                    claim_id,
  output logic                              cmpl_vld,
  output logic [IDW-1:0]                    cmpl_id
);
  dec_t              d;
  int                idx_i;
  int                slot_i;
  int                word_i;
  logic              rd_go;
  logic              wr_go;
  logic              slot_ok;
  logic              on_claim;
  logic [IDW-1:0]    slot_win;
  logic [BUS_DW-1:0] rd_nxt;

  always_comb begin
    d        = decode(bus_addr);
    idx_i    = int'(d.idx);
    slot_i   = int'(d.slot);
    word_i   = int'(d.sub);
    rd_go    = bus_req && !bus_we && d.hit;
    wr_go    = bus_req && bus_we && d.hit;
    slot_ok  = (slot_i < NUM_CTX);
    on_claim = (d.region == RG_CTX) && slot_ok && (d.sub == 2'd1);
    slot_win = '0;
    for (int c = 0; c < NUM_CTX; c++)
      if (c == slot_i) slot_win = win_id[c];
  end

  // read mux
  always_comb begin
    rd_nxt = '0;
    case (d.region)
      RG_PRIO: begin
        for (int s = 1; s <= NUM_SRC; s++)
          if (s == idx_i) rd_nxt[PRIO_W-1:0] = prio[s];
      end
      RG_ENA: begin
        for (int c = 0; c < NUM_CTX; c++)
          if (c == slot_i)
            for (int s = 1; s <= NUM_SRC; s++)
              if ((s / 32) == word_i) rd_nxt[s % 32] = en[c][s];
      end
      RG_CTX: begin
        for (int c = 0; c < NUM_CTX; c++)
          if (c == slot_i) begin
            if (d.sub == 2'd0)      rd_nxt[PRIO_W-1:0] = thr[c];
            else if (d.sub == 2'd1) rd_nxt[IDW-1:0]    = win_id[c];
          end
      end
      default: rd_nxt = '0;
    endcase
  end

  // register writes and registered read data
  always_ff @(posedge clk) begin
    if (rst) begin
      prio      <= '0;
      en        <= '0;
      thr       <= '0;
      bus_rdata <= '0;
    end else begin
      bus_rdata <= rd_go ? rd_nxt : '0;
      if (wr_go) begin
        case (d.region)
          RG_PRIO: begin
            for (int s = 1; s <= NUM_SRC; s++)
              if (s == idx_i) prio[s] <= bus_wdata[PRIO_W-1:0];
          end
          RG_ENA: begin
            for (int c = 0; c < NUM_CTX; c++)
              if (c == slot_i)
                for (int s = 1; s <= NUM_SRC; s++)
                  if ((s / 32) == word_i) en[c][s] <= bus_wdata[s % 32];
          end
          RG_CTX: begin
            for (int c = 0; c < NUM_CTX; c++)
              if ((c == slot_i) && (d.sub == 2'd0)) thr[c] <= bus_wdata[PRIO_W-1:0];
          end
          default: ;
        endcase
      end
    end
  end

  // claim on read, complete on write of the same register
  always_comb begin
    claim_vld = rd_go && on_claim && (slot_win != '0);
    claim_id  = slot_win;
    cmpl_vld  = wr_go && on_claim && (bus_wdata != '0) &&
                (bus_wdata <= BUS_DW'(NUM_SRC));
    cmpl_id   = bus_wdata[IDW-1:0];
  end
endmodule

// File: rtl/irq_claim_ctrl.sv
module irq_claim_ctrl
  import icc_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SRC:1]     src_lvl,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [BUS_AW-1:0]    bus_addr,
  input  logic [BUS_DW-1:0]    bus_wdata,
  output logic [BUS_DW-1:0]    bus_rdata,
  output logic [NUM_CTX-1:0]   irq_o
);
  localparam int IDW = $clog2(NUM_SRC + 1);

  logic [NUM_SRC:1]                  pend;
  logic [NUM_SRC:1]                  busy;
  logic [NUM_SRC:1][PRIO_W-1:0]      prio;
  logic [NUM_CTX-1:0][NUM_SRC:1]     en;
  logic [NUM_CTX-1:0][PRIO_W-1:0]    thr;
  logic [NUM_CTX-1:0][IDW-1:0]       win_id;
  logic                              claim_vld;
  logic [IDW-1:0]                    claim_id;
  logic                              cmpl_vld;
  logic [IDW-1:0]                    cmpl_id;

  icc_regs #(
    .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W), .IDW(IDW)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .win_id(win_id), .prio(prio), .en(en), .thr(thr), .bus_rdata(bus_rdata),
    .claim_vld(claim_vld), .claim_id(claim_id),
    .cmpl_vld(cmpl_vld), .cmpl_id(cmpl_id)
  );

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_gw
    icc_gateway u_gw (
      .clk(clk), .rst(rst), .lvl(src_lvl[s]),
      .take(claim_vld && (claim_id == IDW'(s))),
      .done(cmpl_vld && (cmpl_id == IDW'(s))),
      .pend(pend[s]), .busy(busy[s])
    );
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_arb
    icc_arbiter #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDW(IDW)
    ) u_arb (
      .clk(clk), .rst(rst), .pend(pend), .en(en[c]), .prio(prio),
      .thr(thr[c]), .win_id(win_id[c]), .irq(irq_o[c])
    );
  end
endmodule

// File: rtl/irq_claim_ctrl_chk.sv
module irq_claim_ctrl_chk #(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int IDW     = 5
) (
  input logic                           clk,
  input logic                           rst,
  input logic [NUM_SRC:1]               pend,
  input logic [NUM_SRC:1]               busy,
  input logic [NUM_SRC:1][PRIO_W-1:0]   prio,
  input logic [NUM_CTX-1:0][PRIO_W-1:0] thr,
  input logic [NUM_CTX-1:0][IDW-1:0]    win_id,
  input logic                           claim_vld,
  input logic [IDW-1:0]                 claim_id,
  input logic                           cmpl_vld,
  input logic [IDW-1:0]                 cmpl_id,
  input logic [31:0]                    bus_rdata
);
  logic [NUM_SRC:1]   claim_oh;
  logic [NUM_SRC:1]   cmpl_oh;
  logic [PRIO_W-1:0]  claim_prio;

  always_comb begin
    claim_prio = '0;
    for (int s = 1; s <= NUM_SRC; s++) begin
      claim_oh[s] = claim_vld && (int'(claim_id) == s);
      cmpl_oh[s]  = cmpl_vld && (int'(cmpl_id) == s);
      if (int'(claim_id) == s) claim_prio = prio[s];
    end
  end

  // R8: a source is never pending and in service at once
  a_r8_pend_busy_excl: assert property (@(posedge clk) disable iff (rst)
    (pend & busy) == '0);

  // R7: the claimed source leaves pending and enters service
  a_r7_claim_moves: assert property (@(posedge clk) disable iff (rst)
    claim_vld |=> ((busy & $past(claim_oh)) == $past(claim_oh)) &&
                  ((pend & $past(claim_oh)) == '0));

  // R7: the read data of a claim is the claimed ID
  a_r7_claim_data: assert property (@(posedge clk) disable iff (rst)
    claim_vld |=> bus_rdata == 32'($past(claim_id)));

  // R8: an in-service source cannot re-latch a request
  a_r8_no_relatch: assert property (@(posedge clk) disable iff (rst)
    (pend & ~$past(pend) & $past(busy)) == '0);

  // R10: a valid completion releases the source
  a_r10_complete_frees: assert property (@(posedge clk) disable iff (rst)
    cmpl_vld |=> (busy & $past(cmpl_oh)) == '0);

  // R11: a priority-0 source is never handed out
  a_r11_no_zero_prio: assert property (@(posedge clk) disable iff (rst)
    claim_vld |-> claim_prio != '0);

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    logic [PRIO_W-1:0] wp;
    always_comb begin
      wp = '0;
      for (int s = 1; s <= NUM_SRC; s++)
        if (int'(win_id[c]) == s) wp = prio[s];
    end
    // R4: a winner always beats the context threshold strictly
    a_r4_strict_thr: assert property (@(posedge clk) disable iff (rst)
      (win_id[c] != '0) |-> (wp > thr[c]));
  end
endmodule

bind irq_claim_ctrl irq_claim_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W), .IDW(IDW)
) u_chk (.*);

// File: tb/irq_claim_ctrl_bench.sv
module irq_claim_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  // vectors: source pulse mask (bit s = source s), context-0 enables,
  // context-0 threshold, expected claim ID
  localparam logic [31:0] V_SRC [NV] = '{32'h0000_0008, 32'h0000_0028, 32'h0000_0220,
    32'h0010_0020, 32'h0000_1008, 32'h0000_0008, 32'h0000_0080, 32'h8010_0000,
    32'h8000_0000, 32'h0010_1200};
  localparam logic [31:0] V_EN [NV] = '{32'hFFFF_FFFE, 32'hFFFF_FFFE, 32'hFFFF_FFFE,
    32'h0000_0020, 32'hFFFF_FFFE, 32'hFFFF_FFFE, 32'hFFFF_FFFE, 32'hFFFF_FFFE,
    32'hFFFF_FFFE, 32'h0000_1200};
  localparam logic [31:0] V_THR [NV] = '{0, 0, 0, 0, 2, 2, 0, 6, 0, 0};
  localparam logic [31:0] V_EXP [NV] = '{3, 5, 5, 5, 12, 0, 0, 20, 31, 9};
  localparam string V_TAG [NV] = '{"R5", "R5", "R5", "R3", "R4", "R4", "R11", "R5", "R5", "R3"};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:1] src_lvl = '0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq_o;
  logic [31:0] rd;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_claim_ctrl u_irq_claim_ctrl (
    .clk(clk), .rst(rst), .src_lvl(src_lvl), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic logic [11:0] a_prio(int s); return 12'(4 * s); endfunction
  function automatic logic [11:0] a_ena(int c);  return 12'(32'h200 + 16 * c); endfunction
  function automatic logic [11:0] a_thr(int c);  return 12'(32'h400 + 16 * c); endfunction
  function automatic logic [11:0] a_clm(int c);  return 12'(32'h404 + 16 * c); endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    v = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse(input logic [31:0] mask);
    @(negedge clk);
    src_lvl = mask[31:1];
    @(negedge clk);
    src_lvl = '0;
  endtask

  task automatic drain();
    logic [31:0] id;
    bus_wr(a_ena(0), 32'hFFFF_FFFE);
    bus_wr(a_thr(0), 32'h0);
    for (int k = 0; k < 40; k++) begin
      bus_rd(a_clm(0), id);
      if (id == 32'h0) break;
      bus_wr(a_clm(0), id);
    end
    settle();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 irq", {30'b0, irq_o}, 32'h0);
    bus_rd(a_clm(0), rd); chk("R1 claim", rd, 32'h0);
    bus_rd(a_prio(5), rd); chk("R1 prio", rd, 32'h0);
    bus_rd(a_thr(1), rd);  chk("R1 thr", rd, 32'h0);

    // R2: priority map
    bus_wr(a_prio(3), 2);  bus_wr(a_prio(5), 6);  bus_wr(a_prio(9), 6);
    bus_wr(a_prio(12), 4); bus_wr(a_prio(20), 7);
    bus_wr(a_prio(31), 32'hFFFF_FFF9);
    bus_rd(a_prio(31), rd); chk("R2 truncate", rd, 32'h1);
    bus_rd(a_prio(20), rd); chk("R2 readback", rd, 32'h7);
    bus_wr(a_prio(0), 7);
    bus_rd(a_prio(0), rd);  chk("R2 id0", rd, 32'h0);

    // R3: enable map, bit 0 absent
    bus_wr(a_ena(1), 32'hFFFF_FFFF);
    bus_rd(a_ena(1), rd); chk("R3 bit0", rd, 32'hFFFF_FFFE);
    bus_wr(a_ena(1), 32'h0);
    bus_rd(a_ena(1), rd); chk("R3 clear", rd, 32'h0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      bus_wr(a_ena(0), V_EN[v]);
      bus_wr(a_thr(0), V_THR[v]);
      pulse(V_SRC[v]);
      settle();
      chk({V_TAG[v], " irq"}, {31'b0, irq_o[0]}, {31'b0, V_EXP[v] != 0});
      bus_rd(a_clm(0), rd);
      chk({V_TAG[v], " claim"}, rd, V_EXP[v]);
      if (rd != 0) bus_wr(a_clm(0), rd);
      drain();
    end

    // R7: empty claim
    bus_rd(a_clm(0), rd); chk("R7 empty claim", rd, 32'h0);
    chk("R7 irq idle", {31'b0, irq_o[0]}, 32'h0);

    // R6: one register between pending and the line
    @(negedge clk); src_lvl[12] = 1'b1;
    @(negedge clk); src_lvl[12] = 1'b0;
    chk("R6 not yet", {31'b0, irq_o[0]}, 32'h0);
    @(negedge clk);
    chk("R6 raised", {31'b0, irq_o[0]}, 32'h1);
    drain();

    // R8: held input across a claim
    @(negedge clk); src_lvl[5] = 1'b1;
    settle();
    bus_rd(a_clm(0), rd); chk("R8 claim", rd, 32'd5);
    settle();
    chk("R8 line low", {31'b0, irq_o[0]}, 32'h0);
    bus_rd(a_clm(0), rd); chk("R8 no reclaim", rd, 32'h0);
    bus_wr(a_clm(0), 32'd5);
    settle();
    chk("R8 relatch", {31'b0, irq_o[0]}, 32'h1);
    bus_rd(a_clm(0), rd); chk("R8 claim again", rd, 32'd5);
    src_lvl[5] = 1'b0;
    bus_wr(a_clm(0), 32'd5);
    settle();
    chk("R8 done", {31'b0, irq_o[0]}, 32'h0);

    // R9: short pulse is latched
    pulse(32'h0010_0000);
    settle(); settle();
    chk("R9 latched", {31'b0, irq_o[0]}, 32'h1);
    bus_rd(a_clm(0), rd); chk("R9 claim", rd, 32'd20);
    bus_wr(a_clm(0), rd);

    // R10: bad completions leave the source in service
    @(negedge clk); src_lvl[12] = 1'b1;
    settle();
    bus_rd(a_clm(0), rd); chk("R10 claim", rd, 32'd12);
    bus_wr(a_clm(0), 32'd0);
    bus_wr(a_clm(0), 32'd44);
    bus_wr(12'h454, 32'd12);
    settle();
    chk("R10 still busy", {31'b0, irq_o[0]}, 32'h0);
    bus_wr(a_clm(0), 32'd12);
    settle();
    chk("R10 released", {31'b0, irq_o[0]}, 32'h1);
    bus_rd(a_clm(0), rd);
    src_lvl[12] = 1'b0;
    bus_wr(a_clm(0), 32'd12);

    // R4: equal priority blocked, one below passes
    bus_wr(a_ena(0), 32'h8);
    bus_wr(a_thr(0), 32'd2);
    pulse(32'h8);
    settle();
    chk("R4 equal blocked", {31'b0, irq_o[0]}, 32'h0);
    bus_wr(a_thr(0), 32'd1);
    settle();
    chk("R4 above passes", {31'b0, irq_o[0]}, 32'h1);
    bus_rd(a_thr(0), rd); chk("R4 thr readback", rd, 32'd1);
    bus_rd(a_clm(0), rd); chk("R4 claim", rd, 32'd3);
    bus_wr(a_clm(0), 32'd3);
    bus_wr(a_thr(0), 32'd0);

    // R12: shared source, two contexts
    bus_wr(a_ena(1), 32'h8);
    pulse(32'h8);
    settle();
    chk("R12 both high", {30'b0, irq_o}, 32'h3);
    bus_rd(a_clm(1), rd); chk("R12 ctx1 claim", rd, 32'd3);
    settle();
    chk("R12 both low", {30'b0, irq_o}, 32'h0);
    bus_rd(a_clm(0), rd); chk("R12 ctx0 empty", rd, 32'h0);
    bus_wr(a_clm(1), 32'd3);

    summary();
    $finish;
  end
endmodule